// File: doc/BRIEF.md
# Fixed-Width Instruction Decoder

This block decodes one 16-bit instruction word per cycle for a small 32-bit register machine. Each instruction has two octets and always sits on a 2-byte boundary. The first octet carries a marker bit, a 3-bit subtype and a 4-bit opcode. The second octet holds two 4-bit register operands, and the same byte read whole is an 8-bit immediate. The decoder splits the word into these fields. It turns the opcode into sixteen one-hot operation strobes and works out the operand mode from the subtype. It also flags words whose marker bit is clear as illegal.

The decode is combinational. Its result passes through one output register, and a valid bit travels with the data. The result of a word offered in one cycle appears on the outputs after the next rising clock edge. Every output is zero whenever no valid word was offered, and also after reset. The block does not fetch, execute or touch memory.

Top module: `insn16_decoder`

## Requirements
- R1: The value of `in_valid` on a clock edge shows on `out_valid` right after that edge. The latency is exactly one cycle.
- R2: A word offered as valid with bit 7 of the first octet at 0 (first octet 0x00 to 0x7F) sets `out_illegal` to 1. All strobes are then 0, and subtype, indices, immediate and mode are all 0.
- R3: A legal word drives exactly one strobe. The strobe index equals the opcode, which is first-octet bits 3:0. The order from bit 0 to bit 15 is add, and, call, compare, divide, jump, move, multiply, or, pop, push, return, shift left, shift right, subtract, exclusive or.
- R4: For a legal word, `out_subtype` equals first-octet bits 6:4.
- R5: For a legal word, `out_mode` follows the subtype. Subtypes 0 to 3 give 1 (immediate into byte lane 0 to 3 of R0). Subtype 4 gives 2 (register to register), 5 gives 3 (memory destination), 6 gives 4 (memory source) and 7 gives 5 (memory to memory). Code 0 means no mode.
- R6: For a legal word, `out_dst` equals second-octet bits 3:0 and `out_src` equals second-octet bits 7:4. For example, 0xC6,0x1F gives a move with destination 15 and source 1.
- R7: For a legal word, `out_imm` equals the whole second octet. Its upper nibble is the source operand and its lower nibble is the destination operand.
- R8: A cycle with `in_valid` low makes every output 0 after the next edge.
- R9: A synchronous active-high `rst` makes every output 0 after the edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_hi | input | 8 | First octet: marker, subtype, opcode |
| in_lo | input | 8 | Second octet: operand nibbles / immediate |
| out_valid | output | 1 | Decoded result present |
| out_illegal | output | 1 | Marker bit was clear |
| out_op_strobe | output | 16 | One-hot operation strobes |
| out_subtype | output | 3 | Subtype field |
| out_dst | output | 4 | Destination register index |
| out_src | output | 4 | Source register index |
| out_imm | output | 8 | 8-bit immediate |
| out_mode | output | 3 | Operand mode code |

## Verification
Two functions can act on the same word: the illegal flag and the strobe decoder. Every illegal first octet still has an opcode nibble and a subtype, so both see the same input. The bench sends first octets with bit 7 clear across all sixteen opcode nibbles, mixed in randomly between legal words. It expects the illegal flag set, every strobe low and every field zero. A legal word that follows an illegal one must give back exactly its own strobe. This shows that no state carries over from the illegal word.

// File: rtl/insn16_pkg.sv
package insn16_pkg;

    localparam int OCTET_W  = 8;
    localparam int OPC_W    = 4;
    localparam int SUB_W    = 3;
    localparam int REG_W    = 4;
    localparam int NUM_OPS  = 1 << OPC_W;
    localparam int MODE_W   = 3;
    localparam int MARK_BIT = OCTET_W - 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_NONE    = 3'd0,
        MODE_LANEIMM = 3'd1,
        MODE_REGREG  = 3'd2,
        MODE_MEMDST  = 3'd3,
        MODE_MEMSRC  = 3'd4,
        MODE_MEMMEM  = 3'd5
    } opmode_e;

    typedef struct packed {
        logic                 valid;
        logic                 illegal;
        logic [NUM_OPS-1:0]   strobe;
        logic [SUB_W-1:0]     subtype;
        logic [REG_W-1:0]     dst;
        logic [REG_W-1:0]     src;
        logic [OCTET_W-1:0]   imm;
        opmode_e              mode;
    } dec_word_t;

    function automatic opmode_e mode_of(input logic [SUB_W-1:0] sub);
        opmode_e m;
        case (sub)
            3'd4:    m = MODE_REGREG;
            3'd5:    m = MODE_MEMDST;
            3'd6:    m = MODE_MEMSRC;
            3'd7:    m = MODE_MEMMEM;
            default: m = MODE_LANEIMM;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/insn16_field_split.sv
module insn16_field_split
    import insn16_pkg::*;
(
    input  logic [OCTET_W-1:0] hi,
    input  logic [OCTET_W-1:0] lo,
    output logic               legal,
    output logic [OPC_W-1:0]   opcode,
    output logic [SUB_W-1:0]   subtype,
    output logic [REG_W-1:0]   dst,
    output logic [REG_W-1:0]   src,
    output logic [OCTET_W-1:0] imm
);
    always_comb begin
        legal   = hi[MARK_BIT];
        opcode  = hi[OPC_W-1:0];
        subtype = hi[OPC_W +: SUB_W];
        dst     = lo[REG_W-1:0];
        src     = lo[REG_W +: REG_W];
        imm     = {src, dst};
    end
endmodule

// File: rtl/insn16_strobe_dec.sv
module insn16_strobe_dec
    import insn16_pkg::*;
(
    input  logic               en,
    input  logic [OPC_W-1:0]   opcode,
    output logic [NUM_OPS-1:0] strobe
);
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_strobe
        assign strobe[g] = en && (opcode == OPC_W'(g));
    end
endmodule

// File: rtl/insn16_out_reg.sv
module insn16_out_reg
    import insn16_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dec_word_t d,
    output dec_word_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/insn16_decoder.sv
module insn16_decoder
    import insn16_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [7:0]   in_hi,
    input  logic [7:0]   in_lo,
    output logic         out_valid,
    output logic         out_illegal,
    output logic [15:0]  out_op_strobe,
    output logic [2:0]   out_subtype,
    output logic [3:0]   out_dst,
    output logic [3:0]   out_src,
    output logic [7:0]   out_imm,
    output logic [2:0]   out_mode
);
    logic               f_legal;
    logic [OPC_W-1:0]   f_opc;
    logic [SUB_W-1:0]   f_sub;
    logic [REG_W-1:0]   f_dst;
    logic [REG_W-1:0]   f_src;
    logic [OCTET_W-1:0] f_imm;
    logic [NUM_OPS-1:0] f_strobe;
    logic               accept;
    dec_word_t          d_next;
    dec_word_t          d_q;

    insn16_field_split u_split (
        .hi(in_hi), .lo(in_lo), .legal(f_legal), .opcode(f_opc),
        .subtype(f_sub), .dst(f_dst), .src(f_src), .imm(f_imm)
    );

    assign accept = in_valid && f_legal;

    insn16_strobe_dec u_strobe (
        .en(accept), .opcode(f_opc), .strobe(f_strobe)
    );

    always_comb begin
        d_next         = '0;
        d_next.valid   = in_valid;
        d_next.illegal = in_valid && !f_legal;
        d_next.strobe  = f_strobe;
        if (accept) begin
            d_next.subtype = f_sub;
            d_next.dst     = f_dst;
            d_next.src     = f_src;
            d_next.imm     = f_imm;
            d_next.mode    = mode_of(f_sub);
        end
    end

    insn16_out_reg u_oreg (.clk(clk), .rst(rst), .d(d_next), .q(d_q));

    assign out_valid     = d_q.valid;
    assign out_illegal   = d_q.illegal;
    assign out_op_strobe = d_q.strobe;
    assign out_subtype   = d_q.subtype;
    assign out_dst       = d_q.dst;
    assign out_src       = d_q.src;
    assign out_imm       = d_q.imm;
    assign out_mode      = d_q.mode;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_MARKER_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_hi[7]) |=> (out_illegal && out_op_strobe == '0)); // R2
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_mode == 3'd0 && out_imm == '0 && out_subtype == '0)); // R2
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |-> $countones(out_op_strobe) == 1); // R3
    AST_STROBE_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_hi[7]) |=> out_op_strobe[$past(in_hi[3:0])]); // R3
    AST_LANE_MODE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && !out_subtype[2]) |-> out_mode == 3'd1); // R5
    AST_IMM_NIBBLES: assert property (@(posedge clk) disable iff (rst)
        out_imm == {out_src, out_dst}); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_illegal && out_op_strobe == '0 && out_mode == 3'd0)); // R8
endmodule

// File: tb/insn16_decoder_bench.sv
module insn16_decoder_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_hi, in_lo;
    logic        out_valid, out_illegal;
    logic [15:0] out_op_strobe;
    logic [2:0]  out_subtype, out_mode;
    logic [3:0]  out_dst, out_src;
    logic [7:0]  out_imm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    insn16_decoder u_insn16_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi(in_hi), .in_lo(in_lo),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_op_strobe(out_op_strobe),
        .out_subtype(out_subtype), .out_dst(out_dst), .out_src(out_src),
        .out_imm(out_imm), .out_mode(out_mode)
    );

    function automatic logic [2:0] exp_mode(input logic [2:0] s);
        if (s < 3'd4) return 3'd1;
        return 3'(s - 3'd2);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input logic v, input logic [7:0] h, input logic [7:0] l);
        logic lg;
        lg = v && h[7];
        chk("R1 valid",   16'(out_valid), 16'(v));
        chk("R2 illegal", 16'(out_illegal), 16'(v && !h[7]));
        chk("R3 strobe",  out_op_strobe, lg ? (16'd1 << h[3:0]) : 16'd0);
        chk("R4 subtype", 16'(out_subtype), lg ? 16'(h[6:4]) : 16'd0);
        chk("R5 mode",    16'(out_mode), lg ? 16'(exp_mode(h[6:4])) : 16'd0);
        chk("R6 dst",     16'(out_dst), lg ? 16'(l[3:0]) : 16'd0);
        chk("R6 src",     16'(out_src), lg ? 16'(l[7:4]) : 16'd0);
        chk("R7 imm",     16'(out_imm), lg ? 16'(l) : 16'd0);
    endtask

    task automatic apply(input logic v, input logic [7:0] h, input logic [7:0] l);
        in_valid = v; in_hi = h; in_lo = l;
        @(posedge clk);
        @(negedge clk);
        check_all(v, h, l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_0017;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 1'b1; in_hi = 8'hC6; in_lo = 8'h1F;
        @(posedge clk); @(negedge clk);
        check_all(1'b0, 8'h00, 8'h00); // R9 reset clears outputs
        rst = 1'b0;
        apply(1'b1, 8'hC6, 8'h1F);     // R6 move R1 into R15
        apply(1'b1, 8'h86, 8'h20);     // R5 lane 0 immediate
        apply(1'b1, 8'hB6, 8'h23);     // R5 lane 3
        apply(1'b1, 8'h7F, 8'hFF);     // R2 top of invalid range
        apply(1'b1, 8'h00, 8'h00);     // R2 bottom of invalid range
        apply(1'b1, 8'hF0, 8'hA5);     // R3 follows illegal
        apply(1'b0, 8'hC6, 8'h1F);     // R8 idle clears
        for (int op = 0; op < 16; op++) apply(1'b1, 8'(8'h80 | op), 8'(op * 17)); // R3
        for (int s = 0; s < 8; s++)    apply(1'b1, 8'(8'h85 | (s << 4)), 8'h3C);  // R4 R5
        for (int op = 0; op < 16; op++) apply(1'b1, 8'(op | 8'h70), 8'hFF);      // R2 every opcode nibble
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom();
            apply(r[24] | r[25], r[7:0], r[15:8]);
        end
        rst = 1'b1; in_valid = 1'b1; in_hi = 8'hFF; in_lo = 8'hFF;
        @(posedge clk); @(negedge clk);
        check_all(1'b0, 8'h00, 8'h00); // R9 mid-run reset
        rst = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule